// File: doc/BRIEF.md
# Banked Address and I/O Port Decoder

This block builds the 16-bit data address used by load and store operations of an 8-bit accumulator machine. A bank register, loaded by the move-to-bank operation, supplies the upper address byte, and the accumulator supplies the lower byte. This lets an 8-bit datapath reach a 64KB space.

Every access is steered to one of two places. Addresses below 0xFFE0 go to main RAM. The top 32 bytes form an I/O window that never reaches RAM. Inside that window, each even byte selects one of 16 ports, and every odd byte reads as zero. Ports 0 to 7 belong to built-in peripherals, whose read data comes in on a shared input. Ports 8, 9 and 10 are general-purpose I/O: each has an output register and an input pin byte. Ports 11 to 15 are unused.

The address, the RAM enables, the port selects and the read data are combinational functions of the current inputs and the bank register. The bank register and the GPIO output registers change on the clock edge.

Top module: `banked_io_decoder`

## Requirements
- R1: `ram_addr` always equals {bank register, `acc`}, and the bank register is 0x00 after reset.
- R2: With `bank_wr` high at a clock edge, the bank register takes `bank_din`. With `bank_wr` low it keeps its value.
- R3: `ram_re` equals `mem_rd` and `ram_we` equals `mem_wr` when `ram_addr` < 0xFFE0. Both are low when `ram_addr` >= 0xFFE0.
- R4: During a read or write at an even address 0xFFE0 + 2n, `io_sel` has only bit n set. In every other case `io_sel` is zero.
- R5: A write at 0xFFE0 + 2(8+k), for k = 0 to 2, loads `wdata` into `gpio_out[8k+7:8k]` at the next clock edge. All GPIO output registers are 0x00 after reset.
- R6: A read at 0xFFE0 + 2(8+k) returns `gpio_in[8k+7:8k]` on `rdata` in the same cycle.
- R7: A read of an odd address in the window, or of ports 11 to 15, returns 0x00. Writes to those addresses leave `gpio_out` unchanged.
- R8: A read of ports 0 to 7 at an even address returns `periph_rdata`.
- R9: A read below 0xFFE0 returns `ram_rdata`. When `mem_rd` is low, `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_wr | input | 1 | Move-to-bank strobe |
| bank_din | input | 8 | New bank value |
| acc | input | 8 | Accumulator, low address byte |
| mem_rd | input | 1 | Load access this cycle |
| mem_wr | input | 1 | Store access this cycle |
| wdata | input | 8 | Store data |
| ram_rdata | input | 8 | Read data from RAM |
| periph_rdata | input | 8 | Read data from the selected built-in peripheral |
| gpio_in | input | 24 | Input pins of ports 8..10, one byte per port |
| ram_addr | output | 16 | Composed address |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| io_sel | output | 16 | One-hot port select |
| rdata | output | 8 | Read data to the accumulator |
| gpio_out | output | 24 | Output registers of ports 8..10 |

## Verification
Address, RAM enables, port selects and read data are combinational. The bench drives them one nanosecond after a falling edge and checks them before the next rising edge. Bank and GPIO register effects are due one rising edge later, so the bench updates its model at that edge. It then checks `ram_addr` and `gpio_out` one nanosecond after the edge. Reset release passes a two-stage synchronizer, so the bench waits several cycles before it starts stimulus.

// File: rtl/bio_pkg.sv
package bio_pkg;
  typedef enum logic [1:0] {
    PCLS_RESERVED = 2'd0,
    PCLS_GPIO     = 2'd1,
    PCLS_UNUSED   = 2'd2
  } port_class_e;
endpackage

// File: rtl/bio_rst_sync.sv
module bio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/bio_bank_reg.sv
module bio_bank_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] bank_q
);
  logic [DW-1:0] bank_d;

  always_comb begin
    bank_d = bank_q;
    if (load) bank_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end
endmodule

// File: rtl/bio_addr_decode.sv
module bio_addr_decode
  import bio_pkg::*;
#(
  parameter int AW         = 16,
  parameter int WIN_BITS   = 5,
  parameter int GPIO_FIRST = 8,
  parameter int GPIO_NUM   = 3,
  localparam int PW        = WIN_BITS - 1,
  localparam int NPORT     = 1 << PW
) (
  input  logic [AW-1:0]    addr,
  input  logic             access,
  output logic             in_win,
  output logic             odd_byte,
  output port_class_e      pclass,
  output logic [NPORT-1:0] io_sel
);
  logic [PW-1:0] port_idx;

  assign in_win   = &addr[AW-1:WIN_BITS];
  assign odd_byte = addr[0];
  assign port_idx = addr[WIN_BITS-1:1];

  always_comb begin
    if (int'(port_idx) < GPIO_FIRST)                 pclass = PCLS_RESERVED;
    else if (int'(port_idx) < GPIO_FIRST + GPIO_NUM) pclass = PCLS_GPIO;
    else                                             pclass = PCLS_UNUSED;
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_sel
    assign io_sel[i] = access & in_win & ~odd_byte & (port_idx == PW'(i));
  end
endmodule

// File: rtl/bio_gpio_bank.sv
module bio_gpio_bank #(
  parameter int DW       = 8,
  parameter int GPIO_NUM = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [GPIO_NUM-1:0]    wr_sel,
  input  logic [DW-1:0]          wdata,
  output logic [GPIO_NUM*DW-1:0] gpio_q
);
  for (genvar g = 0; g < GPIO_NUM; g++) begin : g_port
    logic [DW-1:0] port_d;
    logic [DW-1:0] port_q;

    always_comb begin
      port_d = port_q;
      if (wr_sel[g]) port_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) port_q <= '0;
      else        port_q <= port_d;
    end

    assign gpio_q[g*DW +: DW] = port_q;
  end
endmodule

// File: rtl/banked_io_decoder.sv
module banked_io_decoder
  import bio_pkg::*;
#(
  parameter int DW         = 8,
  parameter int WIN_BITS   = 5,
  parameter int GPIO_FIRST = 8,
  parameter int GPIO_NUM   = 3,
  localparam int AW        = 2 * DW,
  localparam int NPORT     = 1 << (WIN_BITS - 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bank_wr,
  input  logic [DW-1:0]          bank_din,
  input  logic [DW-1:0]          acc,
  input  logic                   mem_rd,
  input  logic                   mem_wr,
  input  logic [DW-1:0]          wdata,
  input  logic [DW-1:0]          ram_rdata,
  input  logic [DW-1:0]          periph_rdata,
  input  logic [GPIO_NUM*DW-1:0] gpio_in,
  output logic [AW-1:0]          ram_addr,
  output logic                   ram_re,
  output logic                   ram_we,
  output logic [NPORT-1:0]       io_sel,
  output logic [DW-1:0]          rdata,
  output logic [GPIO_NUM*DW-1:0] gpio_out
);
  logic          srst_n;
  logic [DW-1:0] bank_q;
  logic          in_win;
  logic          odd_byte;
  port_class_e   pclass;
  logic [GPIO_NUM-1:0] gpio_wr;

  bio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  bio_bank_reg #(.DW(DW)) u_bank (
    .clk(clk), .rst_n(srst_n), .load(bank_wr), .din(bank_din), .bank_q(bank_q)
  );

  assign ram_addr = {bank_q, acc};

  bio_addr_decode #(
    .AW(AW), .WIN_BITS(WIN_BITS), .GPIO_FIRST(GPIO_FIRST), .GPIO_NUM(GPIO_NUM)
  ) u_dec (
    .addr(ram_addr), .access(mem_rd | mem_wr), .in_win(in_win),
    .odd_byte(odd_byte), .pclass(pclass), .io_sel(io_sel)
  );

  assign ram_re = mem_rd & ~in_win;
  assign ram_we = mem_wr & ~in_win;

  for (genvar g = 0; g < GPIO_NUM; g++) begin : g_wr
    assign gpio_wr[g] = mem_wr & io_sel[GPIO_FIRST + g];
  end

  bio_gpio_bank #(.DW(DW), .GPIO_NUM(GPIO_NUM)) u_gpio (
    .clk(clk), .rst_n(srst_n), .wr_sel(gpio_wr), .wdata(wdata), .gpio_q(gpio_out)
  );

  always_comb begin
    rdata = '0;
    if (mem_rd) begin
      if (!in_win) begin
        rdata = ram_rdata;
      end else if (!odd_byte) begin
        unique case (pclass)
          PCLS_RESERVED: rdata = periph_rdata;
          PCLS_GPIO: begin
            for (int g = 0; g < GPIO_NUM; g++)
              if (io_sel[GPIO_FIRST + g]) rdata = gpio_in[g*DW +: DW];
          end
          default: rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/banked_io_decoder_chk.sv
module banked_io_decoder_chk #(
  parameter int DW = 8,
  parameter int WIN_BITS = 5,
  parameter int GPIO_FIRST = 8,
  parameter int GPIO_NUM = 3,
  localparam int AW = 2 * DW,
  localparam int NPORT = 1 << (WIN_BITS - 1)
) (
  input logic                   clk,
  input logic                   srst_n,
  input logic                   bank_wr,
  input logic [DW-1:0]          bank_din,
  input logic                   mem_rd,
  input logic                   mem_wr,
  input logic [DW-1:0]          wdata,
  input logic [AW-1:0]          ram_addr,
  input logic                   ram_re,
  input logic                   ram_we,
  input logic [NPORT-1:0]       io_sel,
  input logic [DW-1:0]          rdata,
  input logic [GPIO_NUM*DW-1:0] gpio_out
);
  // R2: bank byte of the address follows the loaded value
  assert_bank_load_R2: assert property (@(posedge clk) disable iff (!srst_n)
    bank_wr |=> ram_addr[AW-1:DW] == $past(bank_din));
  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !bank_wr |=> $stable(ram_addr[AW-1:DW]));
  // R3: RAM never enabled inside the I/O window
  assert_ram_win_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (ram_we || ram_re) |-> !(&ram_addr[AW-1:WIN_BITS]));
  // R4: at most one port selected, and only during an access
  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(io_sel));
  assert_sel_idle_R4: assert property (@(posedge clk) disable iff (!srst_n)
    !(mem_rd || mem_wr) |-> io_sel == '0);
  // R5: a store to the first GPIO port lands in its output register
  assert_gpio_wr_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_wr && io_sel[GPIO_FIRST]) |=> gpio_out[DW-1:0] == $past(wdata));
  // R7: without a store, GPIO outputs do not move
  assert_gpio_hold_R7: assert property (@(posedge clk) disable iff (!srst_n)
    !mem_wr |=> $stable(gpio_out));
  // R9: idle read data is zero
  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!srst_n)
    !mem_rd |-> rdata == '0);
endmodule

bind banked_io_decoder banked_io_decoder_chk #(
  .DW(DW), .WIN_BITS(WIN_BITS), .GPIO_FIRST(GPIO_FIRST), .GPIO_NUM(GPIO_NUM)
) u_chk (
  .clk(clk), .srst_n(srst_n), .bank_wr(bank_wr), .bank_din(bank_din),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .wdata(wdata), .ram_addr(ram_addr),
  .ram_re(ram_re), .ram_we(ram_we), .io_sel(io_sel), .rdata(rdata),
  .gpio_out(gpio_out)
);

// File: tb/banked_io_decoder_tb.sv
`timescale 1ns/1ps
module banked_io_decoder_tb;
  logic clk, rst_n, bank_wr, mem_rd, mem_wr;
  logic [7:0] bank_din, acc, wdata, ram_rdata, periph_rdata, rdata;
  logic [23:0] gpio_in, gpio_out;
  logic [15:0] ram_addr, io_sel;
  logic ram_re, ram_we;

  int checks = 0, errors = 0;
  logic [7:0]  bank_m;
  logic [23:0] gpio_m;
  logic        done = 0;

  banked_io_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_din(bank_din), .acc(acc),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wdata(wdata), .ram_rdata(ram_rdata),
    .periph_rdata(periph_rdata), .gpio_in(gpio_in), .ram_addr(ram_addr),
    .ram_re(ram_re), .ram_we(ram_we), .io_sel(io_sel), .rdata(rdata),
    .gpio_out(gpio_out)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic in_win(input logic [15:0] a);
    return a >= 16'hFFE0;
  endfunction

  function automatic logic [15:0] exp_sel(input logic [15:0] a, input logic rd, input logic wr);
    if ((rd || wr) && in_win(a) && !a[0]) return 16'h1 << a[4:1];
    return 16'h0;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic rd,
                                        input logic [7:0] rr, input logic [7:0] pr,
                                        input logic [23:0] gi);
    int p;
    if (!rd) return 8'h00;
    if (!in_win(a)) return rr;
    if (a[0]) return 8'h00;
    p = int'(a[4:1]);
    if (p < 8) return pr;
    if (p < 11) return gi[(p-8)*8 +: 8];
    return 8'h00;
  endfunction

  function automatic string rd_tag(input logic [15:0] a, input logic rd);
    if (!rd) return "R9 idle";
    if (!in_win(a)) return "R9 ram";
    if (a[0] || a[4:1] > 10) return "R7 zero";
    if (a[4:1] < 8) return "R8 periph";
    return "R6 gpio";
  endfunction

  task automatic step(input logic bw, input logic [7:0] bd, input logic [7:0] a,
                      input logic rd, input logic wr, input logic [7:0] wd);
    logic [15:0] ea;
    @(negedge clk);
    bank_wr = bw; bank_din = bd; acc = a; mem_rd = rd; mem_wr = wr; wdata = wd;
    ram_rdata = 8'($urandom); periph_rdata = 8'($urandom); gpio_in = 24'($urandom);
    #1;
    ea = {bank_m, a};
    chk("R1 addr", ram_addr, ea);
    chk("R3 ram_re", ram_re, rd && !in_win(ea));
    chk("R3 ram_we", ram_we, wr && !in_win(ea));
    chk("R4 io_sel", io_sel, exp_sel(ea, rd, wr));
    chk(rd_tag(ea, rd), rdata, exp_rd(ea, rd, ram_rdata, periph_rdata, gpio_in));
    @(posedge clk); #1;
    if (bw) bank_m = bd;
    if (wr && in_win(ea) && !ea[0] && ea[4:1] >= 8 && ea[4:1] <= 10)
      gpio_m[(int'(ea[4:1])-8)*8 +: 8] = wd;
    chk("R2 bank", ram_addr[15:8], bank_m);
    chk((wr && in_win(ea)) ? "R5/R7 gpio_out" : "R5 gpio_out", gpio_out, gpio_m);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 0; bank_wr = 0; bank_din = 0; acc = 0; mem_rd = 0; mem_wr = 0;
    wdata = 0; ram_rdata = 0; periph_rdata = 0; gpio_in = 0;
    bank_m = 0; gpio_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset bank", ram_addr[15:8], 8'h00);
    chk("R5 reset gpio", gpio_out, 24'h0);

    // directed corners
    step(1, 8'hFF, 8'h00, 0, 0, 8'h00);
    step(0, 8'h00, 8'hDF, 1, 1, 8'hAA);   // last RAM byte R3
    step(0, 8'h00, 8'hE0, 1, 0, 8'h00);   // port 0 R8
    step(0, 8'h00, 8'hF0, 0, 1, 8'h5A);   // port 8 write R5
    step(0, 8'h00, 8'hF2, 0, 1, 8'hC3);   // port 9
    step(0, 8'h00, 8'hF4, 0, 1, 8'h7E);   // port 10
    step(0, 8'h00, 8'hF1, 0, 1, 8'h11);   // odd byte R7
    step(0, 8'h00, 8'hF6, 0, 1, 8'h22);   // port 11 unused R7
    step(0, 8'h00, 8'hFE, 1, 0, 8'h00);   // port 15 R7
    step(0, 8'h00, 8'hF4, 1, 0, 8'h00);   // gpio read R6
    step(1, 8'h12, 8'hF0, 1, 0, 8'h00);   // bank change same cycle R2
    step(0, 8'h00, 8'hF0, 0, 1, 8'h99);   // not window with bank 0x12

    for (int i = 0; i < 3000; i++) begin
      logic bw;
      logic [7:0] bd;
      bw = ($urandom % 6) == 0;
      bd = (($urandom % 3) != 0) ? 8'hFF : 8'($urandom);
      step(bw, bd, (($urandom % 2) != 0) ? (8'hE0 | 8'($urandom % 32)) : 8'($urandom),
           ($urandom % 2) == 1, ($urandom % 2) == 1, 8'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule